// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an on-chip agent and an external asynchronous static RAM. The agent issues one word-sized read or write at a time over a valid/ready request port. The block turns each request into a registered sequence of address, chip-select, output-enable and write-strobe levels, and it drives a shared bidirectional data bus. Read data comes back with a single-cycle response pulse.

Every phase length is a whole number of clock cycles. Each one is derived at elaboration from picosecond timing parameters and the clock period. A read holds the strobes low for at least the access time. A write holds the write strobe low for at least the pulse width and the data setup time. Once a read has raised output-enable, the block delays any write until the memory can no longer be driving the bus. With the default parameters and a 5 ns clock, a read takes 3 cycles, the write strobe is low for 3 cycles, and the turnaround is 2 cycles.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until a request is accepted, chip-select, output-enable and write-strobe are all high (inactive), the response pulse is low and ready is high.
- R2: An accepted read drives chip-select and output-enable low (0) together on the cycle after acceptance. Both stay low for exactly RD_CYC cycles (3 by default), and the address holds steady for that whole time.
- R3: Read data is sampled from the bus on the clock edge where output-enable returns high. It appears on the read data output with the response valid high for exactly one cycle, and it keeps that value until the next read completes.
- R4: An accepted write drives chip-select and write-strobe low on the cycle after acceptance. Write-strobe stays low for exactly WE_CYC cycles (3 by default) while output-enable stays high.
- R5: The write data is driven onto the bus for every cycle in which write-strobe is low. The driver lets go on the same edge where write-strobe rises. The memory stores the value present at that point.
- R6: After a write, chip-select stays low for one more cycle after write-strobe rises, and the address holds through that cycle. No new access begins until chip-select has gone high.
- R7: A write may be accepted only once at least TA_CYC clock edges (2 by default) have passed since output-enable rose at the end of a read. Read after read and write after write need no extra gap.
- R8: Ready is low for the whole time an access is in progress. A request held valid during that time is accepted on the first edge after ready returns. Ready is high in idle unless the request is a write still inside the turnaround window.
- R9: Output-enable and write-strobe are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | DATA_W | Captured read data |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce_no | output | 1 | Chip-select, active low |
| sram_oe_no | output | 1 | Output-enable, active low |
| sram_we_no | output | 1 | Write-strobe, active low |
| sram_data_io | inout | DATA_W | Bidirectional data bus |

## Verification
The case that is hardest to reach from the ports is a write held valid while a read is finishing. Ready must stay low through the turnaround window, and that condition depends on the request type as well as the block's state. The stimulus reaches it by keeping valid asserted with the write fields set as soon as each read has been accepted. A pseudo-random mix of back-to-back reads and writes over a small address range then hits the turnaround check from many different states. A bench memory model returns a junk value until the read access time has been met and commits write data only when the strobe rises, so a shortened read or an early driver release shows up as wrong data.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_WHOLD = 2'd3
  } sram_state_e;

  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              drv_off_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              drv_en_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_o  <= '0;
      drv_en_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (load_i) begin
        wdata_o  <= wdata_i;
        drv_en_o <= 1'b1;
      end else if (drv_off_i) begin
        drv_en_o <= 1'b0;   // released on the edge where the strobe rises
      end
      if (cap_i) rdata_o <= bus_i;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 5000,
  parameter int T_RC_PS   = 15000,
  parameter int T_AA_PS   = 15000,
  parameter int T_WC_PS   = 15000,
  parameter int T_PWE_PS  = 12000,
  parameter int T_SD_PS   = 10000,
  parameter int T_AW_PS   = 12000,
  parameter int T_HZOE_PS = 8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  inout  wire  [DATA_W-1:0] sram_data_io
);
  localparam int RD_CYC = max2(cyc_ceil(T_AA_PS, CLK_PS), cyc_ceil(T_RC_PS, CLK_PS));
  localparam int WE_CYC = max2(max2(cyc_ceil(T_PWE_PS, CLK_PS), cyc_ceil(T_SD_PS, CLK_PS)),
                               max2(cyc_ceil(T_AW_PS, CLK_PS), cyc_ceil(T_WC_PS, CLK_PS) - 1));
  localparam int TA_CYC = cyc_ceil(T_HZOE_PS, CLK_PS);
  localparam int MAX_CYC = max2(max2(RD_CYC, WE_CYC), TA_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WE_LD = CW'(WE_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

  sram_state_e state_q;
  logic accept, ph_zero, ta_zero, ph_load, ta_load, drv_en, wr_done, rd_done;
  logic [CW-1:0] ph_val;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready_o = (state_q == ST_IDLE) && (!req_write_i || ta_zero);
  assign accept      = req_valid_i && req_ready_o;
  assign rd_done     = (state_q == ST_READ)  && ph_zero;
  assign wr_done     = (state_q == ST_WRITE) && ph_zero;
  assign ph_load     = accept;
  assign ph_val      = req_write_i ? WE_LD : RD_LD;
  assign ta_load     = rd_done;

  sram_cycle_timer #(.W(CW)) i_phase_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ph_load), .load_val_i(ph_val), .zero_o(ph_zero)
  );

  sram_cycle_timer #(.W(CW)) i_turn_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ta_load), .load_val_i(TA_LD), .zero_o(ta_zero)
  );

  sram_data_path #(.DATA_W(DATA_W)) i_data_path (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept && req_write_i), .wdata_i(req_wdata_i),
    .drv_off_i(wr_done), .cap_i(rd_done), .bus_i(sram_data_io),
    .wdata_o(wdata_q), .drv_en_o(drv_en), .rdata_o(rsp_rdata_o)
  );

  assign sram_data_io = drv_en ? wdata_q : {DATA_W{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sram_addr_o <= '0;
      sram_ce_no  <= 1'b1;
      sram_oe_no  <= 1'b1;
      sram_we_no  <= 1'b1;
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sram_addr_o <= req_addr_i;
          sram_ce_no  <= 1'b0;
          if (req_write_i) begin
            sram_we_no <= 1'b0;
            state_q    <= ST_WRITE;
          end else begin
            sram_oe_no <= 1'b0;
            state_q    <= ST_READ;
          end
        end
        ST_READ: if (ph_zero) begin
          sram_ce_no  <= 1'b1;
          sram_oe_no  <= 1'b1;
          rsp_valid_o <= 1'b1;
          state_q     <= ST_IDLE;
        end
        ST_WRITE: if (ph_zero) begin
          sram_we_no <= 1'b1;
          state_q    <= ST_WHOLD;
        end
        ST_WHOLD: begin
          sram_ce_no <= 1'b1;   // address/data hold cycle ends here
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int TA_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic              drv_en
);
  logic [7:0] since_oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      since_oe <= 8'(TA_CYC);
    else if (!sram_oe_no)             since_oe <= '0;
    else if (since_oe < 8'(TA_CYC))   since_oe <= since_oe + 1'b1;
  end

  p_oe_we_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no));

  p_rsp_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_rsp_at_oe_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(sram_oe_no));

  p_we_in_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

  p_drive_in_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en |-> !sram_we_no);

  p_we_rise_ce_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> !sram_ce_no);

  p_ce_after_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_ce_no) |-> $past(sram_we_no));

  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (since_oe >= 8'(TA_CYC)));

  p_ready_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> sram_ce_no);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .TA_CYC(TA_CYC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .sram_addr_o(sram_addr_o), .sram_ce_no(sram_ce_no), .sram_oe_no(sram_oe_no),
  .sram_we_no(sram_we_no), .drv_en(drv_en)
);

// File: tb/test_sram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sram_seq_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int RD = 3;
  localparam int WE = 3;
  localparam int TA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ce_n, oe_n, we_n;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] s_addr;
  wire  [DW-1:0] s_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_sram_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sram_addr_o(s_addr),
    .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_data_io(s_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural memory: junk until access time met, commits on strobe rise
  logic [DW-1:0] mem [1<<AW];
  int rd_age = 0, we_age = 0;
  logic [AW-1:0] rd_a = '0, wr_a = '0;
  logic [DW-1:0] wr_d = '0;
  logic [DW-1:0] m_out;
  assign m_out = (rd_age >= RD) ? mem[s_addr] : 16'hDEAD;
  assign s_data = (!ce_n && !oe_n) ? m_out : {DW{1'bz}};

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 16'h0101) ^ 16'h3C5A;
  endfunction

  initial for (int i = 0; i < (1<<AW); i++) mem[i] = init_val(i);

  always @(negedge clk) if (rst_n) begin
    if (!ce_n && !oe_n) begin
      if (rd_age > 0 && s_addr != rd_a) rd_age = 0;
      rd_a = s_addr;
      rd_age++;
    end else rd_age = 0;
    if (!ce_n && !we_n) begin
      wr_d = s_data; wr_a = s_addr; we_age++;
    end else if (we_age > 0) begin
      mem[wr_a] = wr_d;
      chk(we_age >= WE, "R4 strobe width", we_age, WE);
      we_age = 0;
    end
  end

  // reference model, edge-indexed
  logic [DW-1:0] ref_mem [1<<AW];
  initial for (int i = 0; i < (1<<AW); i++) ref_mem[i] = init_val(i);
  int cyc = 0, ph = 0, t_end = 0, last_rise = -1000;
  bit e_ce = 1, e_oe = 1, e_we = 1, e_rv = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_rd = '0, e_wd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; ph = 0; last_rise = -1000; e_ce = 1; e_oe = 1; e_we = 1; e_rv = 0;
    end else begin
      int ph0;
      cyc++; e_rv = 0; ph0 = ph;
      case (ph)
        1: if (cyc == t_end) begin
             e_ce = 1; e_oe = 1; e_rv = 1; e_rd = ref_mem[e_addr]; last_rise = cyc; ph = 0;
           end
        2: if (cyc == t_end) begin e_we = 1; ph = 3; end
        3: begin e_ce = 1; ph = 0; end
        default: ;
      endcase
      if (ph0 == 0 && req_valid && (!req_write || cyc - last_rise >= TA)) begin
        e_addr = req_addr; e_ce = 0;
        if (req_write) begin
          ref_mem[req_addr] = req_wdata; e_wd = req_wdata; e_we = 0; t_end = cyc + WE; ph = 2;
        end else begin
          e_oe = 0; t_end = cyc + RD; ph = 1;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit e_rdy;
    #2;
    e_rdy = (ph == 0) && (!req_write || (cyc + 1 - last_rise) >= TA);
    chk(req_ready == e_rdy, "R8/R7 ready", req_ready, e_rdy);
    chk(oe_n == e_oe, "R2 oe_n", oe_n, e_oe);
    chk(we_n == e_we, "R4 we_n", we_n, e_we);
    chk(ce_n == e_ce, "R6 ce_n", ce_n, e_ce);
    if (!e_ce) chk(s_addr == e_addr, "R6 address", s_addr, e_addr);
    chk(rsp_valid == e_rv, "R3 rsp_valid", rsp_valid, e_rv);
    if (e_rv) chk(rsp_rdata == e_rd, "R3 read data", rsp_rdata, e_rd);
    if (!e_we) chk(s_data == e_wd, "R5 bus data", s_data, e_wd);
    chk(!(!oe_n && !we_n), "R9 exclusive strobes", {oe_n, we_n}, 2'b11);
  end

  task automatic issue(input bit w, input int a, input int d);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = DW'(d);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (2) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1 strobes in reset", {ce_n, oe_n, we_n}, 3'b111);
    chk(!rsp_valid, "R1 rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    // write after write, no gap (R7), held requests (R8)
    issue(1, 3, 16'h5A5A);
    issue(1, 4, 16'hC3C3);
    // read after read without turnaround (R7)
    issue(0, 3, 0);
    issue(0, 4, 0);
    // write right behind a read: turnaround window (R7)
    issue(1, 10, 16'h1234);
    issue(0, 10, 0);
    idle(3);
    issue(0, 200, 0);   // untouched location, initial pattern (R3)
    issue(1, 200, 16'hFFFF);
    idle(1);
    issue(0, 200, 0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], int'(lfsr[5:1]), int'(lfsr ^ 16'(i)));
      if (lfsr[6] && lfsr[7]) idle(int'(lfsr[9:8]));
    end
    idle(6);
    for (int i = 0; i < 32; i++) issue(0, i, 0);   // readback (R5)
    idle(8);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule